// File: doc/BRIEF.md
# Priority Bus Ownership Arbiter with Safe Handover Points

This block decides which of three parties may drive a shared system bus: a low-priority CPU, a higher-priority data-transfer controller (DTC), and an external device that asks for the bus to be released. The CPU is the default owner. Each party signals what it is doing: whether a bus cycle is in progress, whether the CPU is inside a multi-part (locked) access, whether the CPU is asleep, and when the DTC has finished one of its transfer phases. From this status the arbiter picks the moments at which ownership may move. Ownership never moves in the middle of a bus cycle, a locked multi-part access or a DTC phase. When the CPU is asleep it moves at once.

Every change of owner passes through an idle stretch of `GAP_CLKS` clocks (one by default) with no grant asserted. This lets the outgoing party remove its strobes before the next party drives. A power-on reset (asynchronous, active low) returns the arbiter to CPU ownership immediately and abandons whatever was in progress. A manual reset keeps all arbiter state. While it is asserted, no new handover starts, so the current cycle finishes under its present owner, and the wait input is masked off.

States: `ST_CPU` (CPU granted), `ST_DTC` (DTC granted), `ST_EXT` (external release acknowledged), `ST_GAP` (no grant, counting idle clocks toward a latched target). Transitions:
- `ST_CPU`→`ST_GAP` when a request is pending and the CPU is at a cycle boundary outside a locked access, or is asleep.
- `ST_DTC`→`ST_GAP` on a phase end when the DTC has dropped its request or an external request is pending.
- `ST_EXT`→`ST_GAP` when the external request is removed.
- `ST_GAP`→target when the idle count expires.
- Any state →`ST_CPU` on power-on reset.

Top module: `bus_handover_arbiter`

## Requirements
- R1: Power-on reset (`por_n` low) immediately sets `cpu_gnt`=1 and `dtc_gnt`=`ext_ack`=0, whatever the previous owner.
- R2: At most one of `cpu_gnt`, `dtc_gnt`, `ext_ack` is high in any clock. Whenever one of them falls, all three are low for exactly `GAP_CLKS` clocks (1 by default) before the next grant rises.
- R3: While the CPU owns the bus and is awake, it keeps the bus as long as `cyc_busy` is high. The first clock edge that sees a pending request with `cyc_busy` low (and `cpu_lock` low) starts the handover. The new grant is high after the second edge.
- R4: While `cpu_lock` is high and the CPU is awake, the CPU keeps the bus even at a cycle boundary.
- R5: With `cpu_sleep` high, a pending request takes the bus from the CPU at the next edge, regardless of `cyc_busy` and `cpu_lock`.
- R6: The DTC keeps the bus until an edge that sees `dtc_phase_end` high. At that edge it gives the bus up only if `dtc_req` is low or `ext_req` is high; otherwise it continues.
- R7: `ext_req` outranks `dtc_req` when both are pending at a release point. `ext_ack` stays high until `ext_req` is low. The bus then goes to the DTC if `dtc_req` is high, else to the CPU.
- R8: While `mrst` is high, no handover starts and the current grant is held (an idle stretch already under way still completes). `wait_out` is 0 while `mrst` is high and equals `wait_in` otherwise.
- R9: With no request pending, the CPU keeps the bus indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, state preserved, handovers frozen |
| cyc_busy | input | 1 | Current owner is inside a bus cycle |
| cpu_lock | input | 1 | CPU is inside a multi-part access |
| cpu_sleep | input | 1 | CPU is in sleep mode |
| dtc_req | input | 1 | DTC bus request |
| dtc_phase_end | input | 1 | DTC is on the last state of a phase |
| ext_req | input | 1 | External bus-release request |
| wait_in | input | 1 | Wait request from the bus |
| cpu_gnt | output | 1 | CPU owns the bus (registered) |
| dtc_gnt | output | 1 | DTC owns the bus (registered) |
| ext_ack | output | 1 | Bus released to the external device (registered) |
| wait_out | output | 1 | Wait request with manual-reset masking |

## Verification
The hardest situations to reach from the ports involve several conditions that must line up on one edge. One is a DTC phase end that arrives while the DTC still requests and an external request is also pending. Another is a manual reset that arrives while a release point is already satisfied. Directed sequences build these step by step: first a request is held against a busy cycle or a lock, then the blocking condition is removed, or `mrst` is raised, on a chosen edge. A long randomized run, with status inputs weighted toward frequent phase ends and boundaries, then covers the interleavings against a behavioural model.

// File: rtl/bus_handover_arbiter_pkg.sv
package bus_handover_arbiter_pkg;

    typedef enum logic [1:0] {
        ST_CPU = 2'd0,
        ST_DTC = 2'd1,
        ST_EXT = 2'd2,
        ST_GAP = 2'd3
    } arb_state_t;

endpackage

// File: rtl/arb_release_eval.sv
module arb_release_eval
    import bus_handover_arbiter_pkg::*;
(
    input  arb_state_t state,
    input  logic       mrst,
    input  logic       cyc_busy,
    input  logic       cpu_lock,
    input  logic       cpu_sleep,
    input  logic       dtc_req,
    input  logic       dtc_phase_end,
    input  logic       ext_req,
    output logic       go,
    output arb_state_t tgt
);

    logic cpu_at_break;
    logic any_req;

    assign cpu_at_break = cpu_sleep | (~cyc_busy & ~cpu_lock);
    assign any_req      = dtc_req | ext_req;

    always_comb begin
        go  = 1'b0;
        tgt = ST_CPU;
        unique case (state)
            ST_CPU: begin
                go  = ~mrst & any_req & cpu_at_break;
                tgt = ext_req ? ST_EXT : ST_DTC;
            end
            ST_DTC: begin
                go  = ~mrst & dtc_phase_end & (ext_req | ~dtc_req);
                tgt = ext_req ? ST_EXT : ST_CPU;
            end
            ST_EXT: begin
                go  = ~mrst & ~ext_req;
                tgt = dtc_req ? ST_DTC : ST_CPU;
            end
            ST_GAP: begin
                go  = 1'b0;
                tgt = ST_CPU;
            end
        endcase
    end

endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
    import bus_handover_arbiter_pkg::*;
#(
    parameter int GAP_CLKS = 1
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       go,
    input  arb_state_t tgt,
    output arb_state_t state,
    output logic       cpu_gnt,
    output logic       dtc_gnt,
    output logic       ext_ack
);

    localparam int GW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CLKS - 1);

    arb_state_t    state_q, state_nxt;
    arb_state_t    tgt_q, tgt_nxt;
    logic [GW-1:0] gcnt_q, gcnt_nxt;

    assign state = state_q;

    always_comb begin
        state_nxt = state_q;
        tgt_nxt   = tgt_q;
        gcnt_nxt  = gcnt_q;
        unique case (state_q)
            ST_CPU, ST_DTC, ST_EXT: begin
                if (go) begin
                    state_nxt = ST_GAP;
                    tgt_nxt   = tgt;
                    gcnt_nxt  = '0;
                end
            end
            ST_GAP: begin
                if (gcnt_q == GAP_LAST) begin
                    state_nxt = tgt_q;
                end else begin
                    gcnt_nxt = gcnt_q + 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_CPU;
            tgt_q   <= ST_CPU;
            gcnt_q  <= '0;
        end else begin
            state_q <= state_nxt;
            tgt_q   <= tgt_nxt;
            gcnt_q  <= gcnt_nxt;
        end
    end

    // registered grant outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cpu_gnt <= 1'b1;
            dtc_gnt <= 1'b0;
            ext_ack <= 1'b0;
        end else begin
            cpu_gnt <= (state_nxt == ST_CPU);
            dtc_gnt <= (state_nxt == ST_DTC);
            ext_ack <= (state_nxt == ST_EXT);
        end
    end

endmodule

// File: rtl/bus_handover_arbiter.sv
module bus_handover_arbiter
    import bus_handover_arbiter_pkg::*;
#(
    parameter int GAP_CLKS = 1
) (
    input  logic clk,
    input  logic por_n,
    input  logic mrst,
    input  logic cyc_busy,
    input  logic cpu_lock,
    input  logic cpu_sleep,
    input  logic dtc_req,
    input  logic dtc_phase_end,
    input  logic ext_req,
    input  logic wait_in,
    output logic cpu_gnt,
    output logic dtc_gnt,
    output logic ext_ack,
    output logic wait_out
);

    arb_state_t state;
    arb_state_t tgt;
    logic       go;

    arb_release_eval u_eval (
        .state         (state),
        .mrst          (mrst),
        .cyc_busy      (cyc_busy),
        .cpu_lock      (cpu_lock),
        .cpu_sleep     (cpu_sleep),
        .dtc_req       (dtc_req),
        .dtc_phase_end (dtc_phase_end),
        .ext_req       (ext_req),
        .go            (go),
        .tgt           (tgt)
    );

    arb_owner_fsm #(.GAP_CLKS(GAP_CLKS)) u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .go      (go),
        .tgt     (tgt),
        .state   (state),
        .cpu_gnt (cpu_gnt),
        .dtc_gnt (dtc_gnt),
        .ext_ack (ext_ack)
    );

    // wait is disregarded while a manual reset drains the current cycle
    assign wait_out = wait_in & ~mrst;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({cpu_gnt, dtc_gnt, ext_ack})); // R2
    AST_IDLE_AFTER_DROP: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(cpu_gnt) || $fell(dtc_gnt) || $fell(ext_ack))
        |-> !(cpu_gnt || dtc_gnt || ext_ack)); // R2
    AST_CPU_BUSY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_gnt && cyc_busy && !cpu_sleep) |=> cpu_gnt); // R3
    AST_CPU_LOCK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_gnt && cpu_lock && !cpu_sleep) |=> cpu_gnt); // R4
    AST_SLEEP_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_gnt && cpu_sleep && !mrst && (dtc_req || ext_req)) |=> !cpu_gnt); // R5
    AST_DTC_PHASE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (dtc_gnt && !dtc_phase_end) |=> dtc_gnt); // R6
    AST_EXT_ACK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (ext_ack && ext_req) |=> ext_ack); // R7
    AST_MRST_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
        (mrst && (cpu_gnt || dtc_gnt || ext_ack))
        |=> $stable({cpu_gnt, dtc_gnt, ext_ack})); // R8

endmodule

// File: tb/sim_bus_handover_arbiter.sv
module sim_bus_handover_arbiter;

    localparam int PERIOD = 10;
    localparam int GAPS   = 1;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic mrst = 0, cyc_busy = 0, cpu_lock = 0, cpu_sleep = 0;
    logic dtc_req = 0, dtc_phase_end = 0, ext_req = 0, wait_in = 0;
    logic cpu_gnt, dtc_gnt, ext_ack, wait_out;

    int compared = 0;
    int mismatched = 0;
    string cur_tag = "R1";

    always #(PERIOD/2) clk = ~clk;

    bus_handover_arbiter #(.GAP_CLKS(GAPS)) u0 (
        .clk(clk), .por_n(por_n), .mrst(mrst), .cyc_busy(cyc_busy),
        .cpu_lock(cpu_lock), .cpu_sleep(cpu_sleep), .dtc_req(dtc_req),
        .dtc_phase_end(dtc_phase_end), .ext_req(ext_req), .wait_in(wait_in),
        .cpu_gnt(cpu_gnt), .dtc_gnt(dtc_gnt), .ext_ack(ext_ack), .wait_out(wait_out)
    );

    // behavioural reference: owner 0=CPU 1=DTC 2=EXT 3=idle gap
    int m_own = 0;
    int m_next = 0;
    int m_idle = 0;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_own = 0; m_idle = 0;
        end else if (m_own == 3) begin
            m_idle = m_idle + 1;
            if (m_idle >= GAPS) m_own = m_next;
        end else if (!mrst) begin
            if (m_own == 0 && (dtc_req || ext_req) &&
                (cpu_sleep || (!cyc_busy && !cpu_lock))) begin
                m_next = ext_req ? 2 : 1; m_own = 3; m_idle = 0;
            end else if (m_own == 1 && dtc_phase_end && (ext_req || !dtc_req)) begin
                m_next = ext_req ? 2 : 0; m_own = 3; m_idle = 0;
            end else if (m_own == 2 && !ext_req) begin
                m_next = dtc_req ? 1 : 0; m_own = 3; m_idle = 0;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (por_n) begin
            chk(cur_tag, "cpu_gnt",  cpu_gnt,  m_own == 0);
            chk(cur_tag, "dtc_gnt",  dtc_gnt,  m_own == 1);
            chk(cur_tag, "ext_ack",  ext_ack,  m_own == 2);
            chk("R8",    "wait_out", wait_out, wait_in & ~mrst);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic grants(input string tag, input logic c, input logic d, input logic e);
        #1;
        chk(tag, "cpu_gnt", cpu_gnt, c);
        chk(tag, "dtc_gnt", dtc_gnt, d);
        chk(tag, "ext_ack", ext_ack, e);
    endtask

    task automatic quiet();
        mrst = 0; cyc_busy = 0; cpu_lock = 0; cpu_sleep = 0;
        dtc_req = 0; dtc_phase_end = 0; ext_req = 0; wait_in = 0;
    endtask

    initial begin
        #(PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state
        #(PERIOD*2 + 1);
        grants("R1", 1, 0, 0);
        @(posedge clk); #1; por_n = 1;
        cyc(1);

        // R9: idle, CPU keeps the bus
        cur_tag = "R9";
        cyc_busy = 1; cyc(2); cyc_busy = 0; cyc(3);
        grants("R9", 1, 0, 0);

        // R3: request held off by a busy cycle
        cur_tag = "R3";
        dtc_req = 1; cyc_busy = 1; cyc(4);
        grants("R3", 1, 0, 0);
        cyc_busy = 0; cyc(1);
        grants("R2", 0, 0, 0);
        cyc(1);
        grants("R3", 0, 1, 0);

        // R6: DTC holds until a phase end with request removed
        cur_tag = "R6";
        cyc(5);
        grants("R6", 0, 1, 0);
        dtc_phase_end = 1; cyc(1); dtc_phase_end = 0;
        grants("R6", 0, 1, 0);
        cyc(2);
        dtc_req = 0; cyc(3);
        grants("R6", 0, 1, 0);
        dtc_phase_end = 1; cyc(1); dtc_phase_end = 0;
        grants("R2", 0, 0, 0);
        cyc(1);
        grants("R6", 1, 0, 0);

        // R4: locked access blocks the handover at a boundary
        cur_tag = "R4";
        cpu_lock = 1; dtc_req = 1; cyc(4);
        grants("R4", 1, 0, 0);
        cpu_lock = 0; cyc(2);
        grants("R4", 0, 1, 0);
        dtc_req = 0; dtc_phase_end = 1; cyc(1); dtc_phase_end = 0; cyc(1);
        grants("R6", 1, 0, 0);

        // R5: sleep releases despite busy and lock
        cur_tag = "R5";
        cyc_busy = 1; cpu_lock = 1; cpu_sleep = 1; dtc_req = 1; cyc(1);
        grants("R5", 0, 0, 0);
        cyc(1);
        grants("R5", 0, 1, 0);
        quiet(); dtc_phase_end = 1; cyc(1); dtc_phase_end = 0; cyc(1);
        grants("R5", 1, 0, 0);

        // R7: external outranks DTC, ack held, then back to DTC
        cur_tag = "R7";
        ext_req = 1; dtc_req = 1; cyc(2);
        grants("R7", 0, 0, 1);
        cyc(4);
        grants("R7", 0, 0, 1);
        ext_req = 0; cyc(1);
        grants("R2", 0, 0, 0);
        cyc(1);
        grants("R7", 0, 1, 0);
        // DTC still requesting, external arrives at a phase end
        ext_req = 1; dtc_phase_end = 1; cyc(1); dtc_phase_end = 0; cyc(1);
        grants("R7", 0, 0, 1);
        ext_req = 0; dtc_req = 0; cyc(2);
        grants("R7", 1, 0, 0);

        // R8: manual reset freezes handover and masks wait
        cur_tag = "R8";
        mrst = 1; wait_in = 1; dtc_req = 1; #1;
        chk("R8", "wait_out", wait_out, 1'b0);
        cyc(4);
        grants("R8", 1, 0, 0);
        mrst = 0; #1;
        chk("R8", "wait_out", wait_out, 1'b1);
        cyc(2);
        grants("R8", 0, 1, 0);

        // R1: power-on reset mid DTC ownership
        cur_tag = "R1";
        por_n = 0; #1;
        grants("R1", 1, 0, 0);
        quiet(); cyc(2); por_n = 1; cyc(2);
        grants("R1", 1, 0, 0);

        // R2: randomized interleavings against the model
        cur_tag = "R2";
        for (int k = 0; k < 3000; k++) begin
            cyc_busy      = ($urandom_range(0, 2) != 0);
            cpu_lock      = ($urandom_range(0, 3) == 0);
            cpu_sleep     = ($urandom_range(0, 9) == 0);
            dtc_req       = ($urandom_range(0, 1) == 0);
            dtc_phase_end = ($urandom_range(0, 2) == 0);
            ext_req       = ($urandom_range(0, 4) == 0);
            mrst          = ($urandom_range(0, 7) == 0);
            wait_in       = ($urandom_range(0, 1) == 0);
            cyc(1);
        end
        quiet(); cyc(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule